// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block is a wall-clock calendar that counts in packed BCD. A prescaler turns a stream of reference pulses (one per cycle of a 32768 Hz source, already brought into the block clock domain as a single-cycle enable) into a one-second step. That step advances a chain of fields: seconds, minutes, hours (always 24-hour), weekday, day of month, month, and a two-digit year. The year digits 00 to 99 map onto the full years 1970 to 2069.

Software sees eight 16-bit words through a simple write strobe and a combinational read port. Writes to the seven time words land in staging registers and leave the running time untouched. Writing the eighth word with its top bit set copies every staged field into the counter in the same cycle, so a new time is always loaded as a whole. The leap-year status is not derived from the year digits when software loads a time. It comes from a flag bit in the year word. Only when the counter itself rolls into a new year does the block recompute that flag.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 0, day 01, month 01, year 00 and leap flag 0.
- R2: Seconds advance once for every PRESCALE reference pulses (default 32768). A commit clears the pulse count, so the first step after a commit comes PRESCALE pulses later.
- R3: Seconds count 00 to 59 in BCD and wrap to 00 with a carry into minutes. Minutes wrap from 59 to 00 with a carry into hours.
- R4: Hours count 00 to 23 and wrap to 00 with a carry into both day and weekday.
- R5: Weekday counts 0 to 6 and wraps from 6 to 0 at each day carry.
- R6: Day wraps to 01 after the last day of its month: 30 for months 04, 06, 09 and 11; 28 for month 02 with leap flag 0; 29 for month 02 with leap flag 1; 31 otherwise.
- R7: Month wraps from 12 to 01 with a carry into year, and year wraps from 99 to 00.
- R8: When the counter moves to a new year, the leap flag becomes 1 exactly when the new year value mod 4 equals 2. Otherwise the flag keeps the value last committed.
- R9: Writes to words 0 to 6 change only staging registers, keep only their field bits, and leave the readable time unchanged until a commit.
- R10: A write of word 7 with bit 15 set loads all seven staged fields in one cycle. A second step that falls in that same cycle is discarded.
- R11: Word map (addr, bits): 0 seconds [6:0]; 1 minutes [6:0]; 2 hours [5:0]; 3 weekday [2:0]; 4 day [5:0]; 5 month [4:0]; 6 year [7:0] with leap flag at bit 15; 7 commit trigger at bit 15. Unused bits read 0, and word 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | One-cycle enable per reference period |
| wr_en | input | 1 | Write strobe for word `addr` |
| addr | input | 3 | Word index for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of word `addr` (combinational) |

## Verification
The hardest case to reach from the ports is a full cascade, where a single second ripples through day, month and year and also recomputes the leap flag. Reaching it by counting from reset would take years of simulated time. Instead, the bench commits times a few seconds before the month and year boundaries, with both leap flag values and with the February 28 and 29 cases, and then steps across the boundary. It also lands a commit in the same cycle as a step, which needs the pulse count held one short of the limit at the exact commit edge. Random committed times that are biased toward year end fill in the rest.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int FLAG_BIT = 15;

    localparam logic [ADDR_W-1:0] W_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] W_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] W_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] W_WDAY = 3'd3;
    localparam logic [ADDR_W-1:0] W_DAY  = 3'd4;
    localparam logic [ADDR_W-1:0] W_MON  = 3'd5;
    localparam logic [ADDR_W-1:0] W_YEAR = 3'd6;
    localparam logic [ADDR_W-1:0] W_TRIG = 3'd7;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [2:0] wday;
        logic [5:0] day;
        logic [4:0] mon;
        logic [7:0] year;
        logic       leap;
    } cal_time_t;

    localparam cal_time_t CAL_RESET = '{
        sec:  7'h00,
        min:  7'h00,
        hour: 6'h00,
        wday: 3'd0,
        day:  6'h01,
        mon:  5'h01,
        year: 8'h00,
        leap: 1'b0
    };

    // Increment a two-digit packed BCD value by one.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    // Last valid day (BCD) of a month given the leap flag.
    function automatic logic [5:0] month_last_day(input logic [4:0] mon,
                                                  input logic       leap);
        logic [5:0] r;
        case (mon)
            5'h02:                      r = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction

    // Leap status of a BCD year offset from the 1970 base: offset mod 4 == 2.
    function automatic logic year_is_leap(input logic [7:0] yr);
        logic [4:0] s;
        s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
        return (s[1:0] == 2'b10);
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic restart,
    output logic sec_tick
);
    localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        sec_tick = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (ref_pulse) begin
            if (cnt_q == LAST) begin
                cnt_d    = '0;
                sec_tick = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cal_stage.sv
module cal_stage
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output cal_time_t         staged,
    output logic              commit
);
    cal_time_t stage_d, stage_q;
    logic      unused_bits;

    assign unused_bits = ^wr_data[14:8];

    always_comb begin
        stage_d = stage_q;
        commit  = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                W_SEC:  stage_d.sec  = wr_data[6:0];
                W_MIN:  stage_d.min  = wr_data[6:0];
                W_HOUR: stage_d.hour = wr_data[5:0];
                W_WDAY: stage_d.wday = wr_data[2:0];
                W_DAY:  stage_d.day  = wr_data[5:0];
                W_MON:  stage_d.mon  = wr_data[4:0];
                W_YEAR: begin
                    stage_d.year = wr_data[7:0];
                    stage_d.leap = wr_data[FLAG_BIT];
                end
                default: commit = wr_data[FLAG_BIT];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= CAL_RESET;
        else        stage_q <= stage_d;
    end

    assign staged = stage_q;
endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_tick,
    input  logic      load,
    input  cal_time_t load_val,
    output cal_time_t cur
);
    cal_time_t time_d, time_q;

    logic       c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] inc_sec, inc_min, inc_hour, inc_day, inc_mon, inc_year;
    logic       unused_hi;

    always_comb begin
        inc_sec  = bcd_inc({1'b0, time_q.sec});
        inc_min  = bcd_inc({1'b0, time_q.min});
        inc_hour = bcd_inc({2'b0, time_q.hour});
        inc_day  = bcd_inc({2'b0, time_q.day});
        inc_mon  = bcd_inc({3'b0, time_q.mon});
        inc_year = bcd_inc(time_q.year);

        c_min  = (time_q.sec  >= 7'h59);
        c_hour = c_min  && (time_q.min  >= 7'h59);
        c_day  = c_hour && (time_q.hour >= 6'h23);
        c_mon  = c_day  && (time_q.day  >= month_last_day(time_q.mon, time_q.leap));
        c_year = c_mon  && (time_q.mon  >= 5'h12);

        time_d = time_q;
        if (load) begin
            time_d = load_val;
        end else if (sec_tick) begin
            time_d.sec = c_min ? 7'h00 : inc_sec[6:0];
            if (c_min) begin
                time_d.min = c_hour ? 7'h00 : inc_min[6:0];
            end
            if (c_hour) begin
                time_d.hour = c_day ? 6'h00 : inc_hour[5:0];
            end
            if (c_day) begin
                time_d.wday = (time_q.wday >= 3'd6) ? 3'd0 : time_q.wday + 3'd1;
                time_d.day  = c_mon ? 6'h01 : inc_day[5:0];
            end
            if (c_mon) begin
                time_d.mon = c_year ? 5'h01 : inc_mon[4:0];
            end
            if (c_year) begin
                time_d.year = (time_q.year >= 8'h99) ? 8'h00 : inc_year;
                time_d.leap = year_is_leap(time_d.year);
            end
        end
    end

    assign unused_hi = ^{inc_sec[7], inc_min[7], inc_hour[7:6], inc_day[7:6], inc_mon[7:5]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) time_q <= CAL_RESET;
        else        time_q <= time_d;
    end

    assign cur = time_q;
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import cal_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic      sec_tick;
    logic      commit;
    cal_time_t staged;
    cal_time_t cur_time;

    cal_prescaler #(.PRESCALE(PRESCALE)) pre_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .restart   (commit),
        .sec_tick  (sec_tick)
    );

    cal_stage stage_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_data (wdata),
        .staged  (staged),
        .commit  (commit)
    );

    cal_counter cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .load     (commit),
        .load_val (staged),
        .cur      (cur_time)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            W_SEC:  rdata[6:0] = cur_time.sec;
            W_MIN:  rdata[6:0] = cur_time.min;
            W_HOUR: rdata[5:0] = cur_time.hour;
            W_WDAY: rdata[2:0] = cur_time.wday;
            W_DAY:  rdata[5:0] = cur_time.day;
            W_MON:  rdata[4:0] = cur_time.mon;
            W_YEAR: begin
                rdata[7:0]      = cur_time.year;
                rdata[FLAG_BIT] = cur_time.leap;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_clock_chk.sv
module bcd_calendar_clock_chk
    import cal_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sec_tick,
    input logic      commit,
    input cal_time_t staged,
    input cal_time_t cur
);
    logic day_end;
    assign day_end = (cur.sec == 7'h59) && (cur.min == 7'h59) && (cur.hour == 6'h23);

    // R10
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cur == $past(staged)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !sec_tick) |=> $stable(cur));

    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !commit && cur.sec == 7'h59) |=>
            (cur.sec == 7'h00 && cur.min != $past(cur.min)));

    // R4
    hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !commit && day_end) |=>
            (cur.hour == 6'h00 && cur.day != $past(cur.day)));

    // R5
    wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !commit && day_end && cur.wday == 3'd6) |=> (cur.wday == 3'd0));

    // R7
    year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !commit && day_end && cur.day == 6'h31 && cur.mon == 5'h12
         && cur.year == 8'h99) |=> (cur.year == 8'h00 && cur.mon == 5'h01));
endmodule

bind bcd_calendar_clock bcd_calendar_clock_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .commit   (commit),
    .staged   (staged),
    .cur      (cur_time)
);

// File: tb/bcd_calendar_clock_tb_top.sv
module bcd_calendar_clock_tb_top;
    localparam int PS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_pulse = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    int m_sec, m_min, m_hr, m_wd, m_day, m_mon, m_yr, m_leap;

    always #5 clk = ~clk;

    bcd_calendar_clock #(.PRESCALE(PS)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int days_of(input int mon, input int leap);
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [15:0] exp_word(input int a);
        case (a)
            0: return {8'h00, to_bcd(m_sec)};
            1: return {8'h00, to_bcd(m_min)};
            2: return {8'h00, to_bcd(m_hr)};
            3: return 16'(m_wd);
            4: return {8'h00, to_bcd(m_day)};
            5: return {8'h00, to_bcd(m_mon)};
            6: return {m_leap[0], 7'h00, to_bcd(m_yr)};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_second();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_wd = (m_wd + 1) % 7;
                    m_day++;
                    if (m_day > days_of(m_mon, m_leap)) begin
                        m_day = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1;
                            m_yr = (m_yr + 1) % 100;
                            m_leap = (m_yr % 4 == 2) ? 1 : 0;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check_word(input int a, input string req);
        logic [15:0] e;
        @(negedge clk);
        addr = 3'(a);
        #1;
        e = exp_word(a);
        n_checks++;
        if (rdata !== e) begin
            n_fails++;
            $display("FAIL %s word %0d: actual %h expected %h", req, a, rdata, e);
        end
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 8; a++) check_word(a, req);
    endtask

    task automatic write_word(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 16'h0000;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0;
        end
    endtask

    task automatic seconds(input int n);
        for (int i = 0; i < n; i++) begin
            pulses(PS);
            model_second();
        end
    endtask

    task automatic load_time(input int s, input int mi, input int h, input int wd,
                             input int d, input int mo, input int y, input int lp);
        write_word(0, {8'h00, to_bcd(s)});
        write_word(1, {8'h00, to_bcd(mi)});
        write_word(2, {8'h00, to_bcd(h)});
        write_word(3, 16'(wd));
        write_word(4, {8'h00, to_bcd(d)});
        write_word(5, {8'h00, to_bcd(mo)});
        write_word(6, {lp[0], 7'h00, to_bcd(y)});
        write_word(7, 16'h8000);
        m_sec = s; m_min = mi; m_hr = h; m_wd = wd;
        m_day = d; m_mon = mo; m_yr = y; m_leap = lp;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0;
        m_day = 1; m_mon = 1; m_yr = 0; m_leap = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R11 word 7 reads 0
        check_all("R1");
        check_word(7, "R11");

        // R2 prescaler: PS-1 pulses do nothing, the PS-th steps
        pulses(PS - 1);
        check_word(0, "R2");
        pulses(1);
        model_second();
        check_word(0, "R2");

        // R2 commit restarts the count
        pulses(2);
        load_time(10, 20, 5, 2, 15, 6, 40, 1);
        pulses(PS - 1);
        check_all("R2");
        pulses(1);
        model_second();
        check_all("R2");

        // R9 staged writes with extra bits stay hidden until commit
        write_word(0, 16'hFF45);
        write_word(2, 16'hC0E3);
        write_word(6, 16'h7F40);
        check_all("R9");
        write_word(7, 16'h7FFF);
        check_all("R9");
        write_word(7, 16'h8000);
        m_sec = 45; m_hr = 23; m_leap = 0;
        check_all("R9");

        // R10 commit in the same cycle as a step
        pulses(PS - 1);
        write_word(0, 16'h0010);
        @(negedge clk);
        ref_pulse = 1'b1; wr_en = 1'b1; addr = 3'd7; wdata = 16'h8000;
        @(negedge clk);
        ref_pulse = 1'b0; wr_en = 1'b0; wdata = 16'h0000;
        m_sec = 10;
        check_all("R10");
        pulses(PS - 1);
        check_word(0, "R10");
        seconds(1);
        check_all("R10");

        // R3 minute and hour carries
        load_time(58, 59, 10, 3, 12, 7, 25, 0);
        seconds(2);
        check_all("R3");
        // R4 R5 day and weekday carry
        load_time(59, 59, 23, 6, 12, 7, 25, 0);
        seconds(1);
        check_all("R4");
        check_word(3, "R5");
        // R6 February with and without leap flag, 30-day month, 31-day month
        load_time(59, 59, 23, 1, 28, 2, 2, 1);
        seconds(1);
        check_all("R6");
        load_time(59, 59, 23, 1, 28, 2, 3, 0);
        seconds(1);
        check_all("R6");
        load_time(59, 59, 23, 4, 30, 4, 50, 0);
        seconds(1);
        check_all("R6");
        load_time(59, 59, 23, 4, 30, 5, 50, 0);
        seconds(1);
        check_all("R6");
        // R7 year 99 to 00, R8 leap recomputed
        load_time(59, 59, 23, 0, 31, 12, 99, 1);
        seconds(1);
        check_all("R7");
        load_time(59, 59, 23, 0, 31, 12, 1, 0);
        seconds(1);
        check_all("R8");
        load_time(59, 59, 23, 0, 31, 12, 2, 1);
        seconds(1);
        check_all("R8");

        // Random committed times and runs
        for (int it = 0; it < 24; it++) begin
            int mo, lp, dd, ss, mi, hh, nsec;
            mo = 1 + int'($urandom % 12);
            lp = int'($urandom % 2);
            if ($urandom % 3 == 0) begin
                mo = 12; dd = 31; hh = 23; mi = 59; ss = 40 + int'($urandom % 20);
            end else begin
                dd = 1 + int'($urandom % days_of(mo, lp));
                hh = int'($urandom % 24);
                mi = int'($urandom % 60);
                ss = int'($urandom % 60);
            end
            load_time(ss, mi, hh, int'($urandom % 7), dd, mo, int'($urandom % 100), lp);
            nsec = 1 + int'($urandom % 150);
            seconds(nsec);
            check_all("R3 R6 R7 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule